// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Operation Decoder

This block holds two independent combinational paths of a simple processor's execute stage. The first is an operation decoder: it takes a 2-bit instruction class and a 6-bit function field and produces a 4-bit operation code. Memory accesses always add, so that base plus offset forms an address. Conditional branches always subtract, so that equality can be read from the zero flag. Register-type instructions take their operation from the function field.

The second path is a 32-bit arithmetic-logic unit. It applies the operation named by a 4-bit code to two operands and returns a result and a zero flag. The operations are bitwise AND, OR and NOR, addition, subtraction and signed set-less-than. In a datapath the decoder's output is wired to the unit's operation input. Both are brought out separately so that each can be driven and observed alone. There are no clocks or registers: every output settles from the current inputs.

Top module: `alu_core`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of the two operands.
- R2: Operation code 4'b0001 gives the bitwise OR of the two operands.
- R3: Operation code 4'b0010 gives the sum of the operands, modulo 2^32.
- R4: Operation code 4'b0110 gives operand A minus operand B, modulo 2^32.
- R5: Operation code 4'b0111 gives 1 when A is less than B as two's-complement signed numbers and 0 otherwise, with all upper bits 0.
- R6: Operation code 4'b1100 gives the bitwise NOR of the two operands.
- R7: Any other operation code gives a result of zero.
- R8: The zero flag is 1 exactly when every bit of the result is 0.
- R9: Class 2'b00 (memory access) decodes to 4'b0010 for any function value.
- R10: Class 2'b01 (branch) decodes to 4'b0110 for any function value.
- R11: Class 2'b10 (register-type) decodes the function field as 6'h20 to 4'b0010, 6'h22 to 4'b0110, 6'h24 to 4'b0000, 6'h25 to 4'b0001, 6'h27 to 4'b1100 and 6'h2A to 4'b0111.
- R12: Class 2'b10 with any other function value, and class 2'b11 with any function value, decode to the unused code 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_class | input | 2 | Instruction class: 00 memory access, 01 branch, 10 register-type, 11 unused |
| ctl_funct | input | 6 | Function field of a register-type instruction |
| ctl_op | output | 4 | Decoded operation code |
| alu_op | input | 4 | Operation code applied to the operands |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_result | output | 32 | Result of the selected operation |
| alu_zero | output | 1 | High when the result is all zeros |

## Verification
The assertions re-check the output every time an input changes. They cover the decoder's forced codes for memory and branch classes, the single-bit shape of the set-less-than result, the zero result of unused codes, and the link between the zero flag and the result. They also check that an equal pair of operands under subtraction raises the zero flag. The exact arithmetic of the operations needs the bench's scenarios. Signed comparison across the sign boundary, wrap-around of addition and subtraction, and the full decoder table are compared against independently computed values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned FUNCT_W = 6;
  localparam int unsigned CLASS_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_NOR  = 4'b1100,
    OP_NONE = 4'b1111
  } alu_op_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG    = 2'b10,
    CLS_RSVD   = 2'b11
  } op_class_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'h27;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] cls_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [OP_W-1:0]    op_o
);
  alu_op_e reg_op;

  // Function-field lookup for register-type instructions
  always_comb begin
    case (funct_i)
      FN_ADD:  reg_op = OP_ADD;
      FN_SUB:  reg_op = OP_SUB;
      FN_AND:  reg_op = OP_AND;
      FN_OR:   reg_op = OP_OR;
      FN_NOR:  reg_op = OP_NOR;
      FN_SLT:  reg_op = OP_SLT;
      default: reg_op = OP_NONE;
    endcase
  end

  always_comb begin
    case (cls_i)
      CLS_MEM:    op_o = OP_ADD;
      CLS_BRANCH: op_o = OP_SUB;
      CLS_REG:    op_o = reg_op;
      default:    op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    nor_o = ~(a_i | b_i);
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             lt_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin_vec;
  logic             ovf;

  // One shared adder: subtraction inverts B and injects a carry
  always_comb begin
    b_eff   = b_i ^ {WIDTH{sub_i}};
    cin_vec = {{(WIDTH-1){1'b0}}, sub_i};
    sum_o   = a_i + b_eff + cin_vec;
    ovf     = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    lt_o    = sum_o[MSB] ^ ovf;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       ctl_class,
  input  logic [5:0]       ctl_funct,
  output logic [3:0]       ctl_op,
  input  logic [3:0]       alu_op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] alu_result,
  output logic             alu_zero
);
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] nor_v;
  logic [WIDTH-1:0] sum_v;
  logic             lt_v;
  logic             do_sub;

  alu_op_decoder u_dec (
    .cls_i   (ctl_class),
    .funct_i (ctl_funct),
    .op_o    (ctl_op)
  );

  alu_bitwise_unit #(.WIDTH(WIDTH)) u_bit (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  assign do_sub = (alu_op == OP_SUB) || (alu_op == OP_SLT);

  alu_arith_unit #(.WIDTH(WIDTH)) u_ari (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sub_i (do_sub),
    .sum_o (sum_v),
    .lt_o  (lt_v)
  );

  always_comb begin
    case (alu_op)
      OP_AND:  alu_result = and_v;
      OP_OR:   alu_result = or_v;
      OP_ADD:  alu_result = sum_v;
      OP_SUB:  alu_result = sum_v;
      OP_SLT:  alu_result = {{(WIDTH-1){1'b0}}, lt_v};
      OP_NOR:  alu_result = nor_v;
      default: alu_result = '0;
    endcase
  end

  assign alu_zero = ~|alu_result;
endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [1:0]       ctl_class,
  input logic [3:0]       ctl_op,
  input logic [3:0]       alu_op,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] alu_result,
  input logic             alu_zero
);
  always_comb begin
    if (ctl_class == 2'b00)
      assert_mem_add_R9: assert (ctl_op == 4'b0010);
    if (ctl_class == 2'b01)
      assert_branch_sub_R10: assert (ctl_op == 4'b0110);
    if (ctl_class == 2'b11)
      assert_rsvd_none_R12: assert (ctl_op == 4'b1111);
    if (alu_op == 4'b0111)
      assert_slt_onebit_R5: assert (alu_result[WIDTH-1:1] == '0);
    if (alu_op == 4'b0011 || alu_op == 4'b1111 || alu_op == 4'b1000)
      assert_unused_zero_R7: assert (alu_result == '0);
    if (alu_zero)
      assert_zero_flag_R8: assert ($countones(alu_result) == 0);
    if (alu_op == 4'b0110 && opnd_a == opnd_b)
      assert_sub_equal_R4: assert (alu_zero);
  end
endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_chk (
  .ctl_class  (ctl_class),
  .ctl_op     (ctl_op),
  .alu_op     (alu_op),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .alu_result (alu_result),
  .alu_zero   (alu_zero)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [1:0]   ctl_class;
  logic [5:0]   ctl_funct;
  logic [3:0]   ctl_op;
  logic [3:0]   alu_op;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] alu_result;
  logic         alu_zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  alu_core #(.WIDTH(W)) dut_i (
    .ctl_class  (ctl_class),
    .ctl_funct  (ctl_funct),
    .ctl_op     (ctl_op),
    .alu_op     (alu_op),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .alu_result (alu_result),
    .alu_zero   (alu_zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] ref_alu(input logic [3:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (op)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 1 : 0;
      4'b1100: return ~(a | b);
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] ref_dec(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    if (c == 2'b11) return 4'b1111;
    case (f)
      6'h20: return 4'b0010;
      6'h22: return 4'b0110;
      6'h24: return 4'b0000;
      6'h25: return 4'b0001;
      6'h27: return 4'b1100;
      6'h2A: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic string req_of_op(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_alu(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] exp_r;
    @(negedge clk);
    alu_op = op; opnd_a = a; opnd_b = b;
    #1;
    exp_r = ref_alu(op, a, b);
    n_cmp++;
    if (alu_result !== exp_r) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h",
               req_of_op(op), op, a, b, alu_result, exp_r);
    end
    n_cmp++;
    if (alu_zero !== (exp_r == '0)) begin
      n_bad++;
      $display("FAIL R8 op=%b zero actual=%b expected=%b", op, alu_zero, (exp_r == '0));
    end
  endtask

  task automatic run_dec(input logic [1:0] c, input logic [5:0] f);
    logic [3:0] exp_o;
    @(negedge clk);
    ctl_class = c; ctl_funct = f;
    #1;
    exp_o = ref_dec(c, f);
    n_cmp++;
    if (ctl_op !== exp_o) begin
      n_bad++;
      $display("FAIL %s class=%b funct=%h op actual=%b expected=%b",
               (c == 2'b00) ? "R9" : (c == 2'b01) ? "R10" :
               (exp_o == 4'b1111) ? "R12" : "R11", c, f, ctl_op, exp_o);
    end
  endtask

  initial begin
    logic [3:0] ops [7];
    int unsigned seed;
    ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100, 4'b1111};
    seed = 32'd20240709;
    void'($urandom(seed));
    rst_n = 1'b0;
    ctl_class = '0; ctl_funct = '0; alu_op = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give AND of zeros, flag high (R1, R8)
    run_alu(4'b0000, '0, '0);

    // Directed corners
    run_alu(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000); // R5: positive max vs negative min -> 0
    run_alu(4'b0111, 32'h8000_0000, 32'h0000_0001); // R5: negative < positive -> 1
    run_alu(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000); // R5: -1 < 0
    run_alu(4'b0111, 32'h0000_0005, 32'h0000_0005); // R5: equal -> 0
    run_alu(4'b0110, 32'h1234_5678, 32'h1234_5678); // R4/R8: equal subtract -> zero
    run_alu(4'b0110, 32'h0000_0000, 32'h0000_0001); // R4: borrow wraps
    run_alu(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001); // R3: wrap to zero
    run_alu(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF); // R6: NOR -> zero
    run_alu(4'b1100, 32'h0000_0000, 32'h0000_0000); // R6: NOR -> all ones
    run_alu(4'b0001, 32'hA5A5_0000, 32'h0000_5A5A); // R2
    run_alu(4'b0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R7: unused code
    run_alu(4'b1000, 32'h1, 32'h1);                 // R7: unused code

    // Exhaustive decoder table (R9..R12)
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++)
        run_dec(c[1:0], f[5:0]);

    // Constrained random operations, mostly valid codes, sometimes any code
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [W-1:0] a, b;
      op = ($urandom_range(0, 4) == 0) ? 4'($urandom) : ops[$urandom_range(0, 6)];
      a  = $urandom;
      b  = ($urandom_range(0, 7) == 0) ? a : W'($urandom);
      run_alu(op, a, b);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule